// File: doc/BRIEF.md
# Grouped Slave Base Address Decoder

This block looks at the upper address bits of a system bus access and decides whether the access targets this module's control registers or its local memory. An 8-bit configuration switch value places the module in one of eight address groups and in one of 32 slots inside that group. Each slot owns one contiguous window of the address space. The bottom of that window holds the control registers and the rest of it maps to local memory.

Slots 0 to 30 are ordinary per-module windows. Slot 31 of every group is a shared broadcast window. Any access inside it raises a one-cycle location-monitor strobe in every module of that group, whatever slot the module itself is set to, and it never selects registers or memory. Register and memory selects are combinational, so the bus handshake logic outside can use them in the same cycle. The broadcast strobe is registered and fires once for each access.

Top module: `grouped_addr_decoder`

## Requirements
- R1: The switch value is loaded into the decoder on every clock edge while `rst` is high. Bits [7:5] are the group and bits [4:0] are the slot. Changes on `cfg_sw` after reset has been released have no effect.
- R2: An access is an own hit only when all of these hold: `addr[31:29]` equals the configured group, `addr[28:24]` equals the configured slot, `as_valid` is 1 and `am_ok` is 1.
- R3: On an own hit whose offset `addr[23:8]` is all zero (the lowest 256 bytes of the window), `reg_sel` is 1 and `mem_sel` is 0 in the same cycle.
- R4: On an own hit whose offset is 256 or more, `mem_sel` is 1 and `reg_sel` is 0 in the same cycle.
- R5: When the configured slot is 31, `reg_sel` and `mem_sel` stay 0 for every address.
- R6: An access with `addr[31:29]` equal to the configured group and `addr[28:24]` equal to 31, qualified by `as_valid` and `am_ok`, makes `lm_strobe` high for exactly one cycle. The pulse starts one clock edge after the first cycle of the access and happens for any configured slot. Such an access never asserts `reg_sel` or `mem_sel`.
- R7: A broadcast access held for several cycles gives only one `lm_strobe` pulse. Another pulse needs the access to be dropped and started again.
- R8: A broadcast access to a different group gives no `lm_strobe`.
- R9: When `as_valid` or `am_ok` is 0, `reg_sel`, `mem_sel` and `lm_strobe` all stay 0.
- R10: While `rst` is high, `lm_strobe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset. The switch is loaded while it is high |
| cfg_sw | input | 8 | Configuration switch: {group[2:0], slot[4:0]} |
| addr | input | 32 | Bus address |
| as_valid | input | 1 | Address strobe: the address is valid |
| am_ok | input | 1 | Access-type qualifier from outside the block |
| reg_sel | output | 1 | Control-register window selected (combinational) |
| mem_sel | output | 1 | Local-memory window selected (combinational) |
| lm_strobe | output | 1 | Location-monitor broadcast strobe (registered, one cycle) |

## Verification
Register and memory selects are due in the same cycle as the address. The bench drives each stimulus on the falling clock edge and samples the selects one nanosecond later, before any rising edge can step in. The broadcast strobe is due after exactly one rising edge, so the bench samples it at the next falling edge and expects it high there. It samples again one falling edge later and expects it low while the access is still held. Configuration checks release reset and change the switch afterwards, then confirm that the old window still decodes.

// File: rtl/grp_dec_pkg.sv
package grp_dec_pkg;
    localparam int GRP_W  = 3;
    localparam int SLOT_W = 5;
    localparam int SW_W   = GRP_W + SLOT_W;

    typedef struct packed {
        logic [GRP_W-1:0]  grp;
        logic [SLOT_W-1:0] slot;
    } dec_cfg_t;

    typedef struct packed {
        logic own_hit;
        logic in_regs;
        logic bcast_hit;
    } match_t;

    function automatic logic is_bcast_slot(input logic [SLOT_W-1:0] s);
        return &s;
    endfunction
endpackage

// File: rtl/gad_cfg_latch.sv
module gad_cfg_latch
    import grp_dec_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [SW_W-1:0] sw,
    output dec_cfg_t        cfg
);
    always_ff @(posedge clk) begin
        if (rst) cfg <= dec_cfg_t'(sw);
    end

    // R1
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(cfg));
endmodule

// File: rtl/gad_matcher.sv
module gad_matcher
    import grp_dec_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int REG_W  = 8
)(
    input  logic [ADDR_W-1:0] addr,
    input  dec_cfg_t          cfg,
    input  logic              qual,
    output match_t            m
);
    localparam int OFF_W = ADDR_W - SW_W;

    dec_cfg_t           field;
    logic [OFF_W-1:0]   off;
    logic               grp_eq;

    assign field  = dec_cfg_t'(addr[ADDR_W-1 -: SW_W]);
    assign off    = addr[OFF_W-1:0];
    assign grp_eq = (field.grp == cfg.grp);

    always_comb begin
        m.own_hit   = qual && grp_eq && (field.slot == cfg.slot)
                      && !is_bcast_slot(cfg.slot);
        m.in_regs   = (off[OFF_W-1:REG_W] == '0);
        m.bcast_hit = qual && grp_eq && is_bcast_slot(field.slot);
    end
endmodule

// File: rtl/gad_lm_pulse.sv
module gad_lm_pulse (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    output logic strobe
);
    logic hit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q  <= 1'b0;
            strobe <= 1'b0;
        end else begin
            hit_q  <= hit;
            strobe <= hit && !hit_q;
        end
    end

    // R7
    lm_single_chk: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);
endmodule

// File: rtl/grouped_addr_decoder.sv
module grouped_addr_decoder
    import grp_dec_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int REG_W  = 8
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [SW_W-1:0]   cfg_sw,
    input  logic [ADDR_W-1:0] addr,
    input  logic              as_valid,
    input  logic              am_ok,
    output logic              reg_sel,
    output logic              mem_sel,
    output logic              lm_strobe
);
    dec_cfg_t cfg;
    match_t   m;
    logic     qual;

    assign qual = as_valid && am_ok;

    gad_cfg_latch u_cfg (
        .clk (clk),
        .rst (rst),
        .sw  (cfg_sw),
        .cfg (cfg)
    );

    gad_matcher #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_match (
        .addr (addr),
        .cfg  (cfg),
        .qual (qual),
        .m    (m)
    );

    gad_lm_pulse u_lm (
        .clk    (clk),
        .rst    (rst),
        .hit    (m.bcast_hit),
        .strobe (lm_strobe)
    );

    assign reg_sel = m.own_hit &&  m.in_regs;
    assign mem_sel = m.own_hit && !m.in_regs;

    // R3
    sel_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({reg_sel, mem_sel}));

    // R5
    bad_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.slot == '1) |-> !(reg_sel || mem_sel));

    // R9
    unqual_chk: assert property (@(posedge clk) disable iff (rst)
        !qual |-> !(reg_sel || mem_sel));

    // R6
    lm_cause_chk: assert property (@(posedge clk) disable iff (rst)
        lm_strobe |-> $past(m.bcast_hit));

    // R6
    bcast_nosel_chk: assert property (@(posedge clk) disable iff (rst)
        m.bcast_hit |-> !(reg_sel || mem_sel));
endmodule

// File: tb/grouped_addr_decoder_bench.sv
module grouped_addr_decoder_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cfg_sw = 8'hA9;
    logic [31:0] addr = '0;
    logic        as_valid = 1'b0;
    logic        am_ok = 1'b0;
    logic        reg_sel, mem_sel, lm_strobe;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    grouped_addr_decoder u_grouped_addr_decoder (
        .clk(clk), .rst(rst), .cfg_sw(cfg_sw), .addr(addr),
        .as_valid(as_valid), .am_ok(am_ok),
        .reg_sel(reg_sel), .mem_sel(mem_sel), .lm_strobe(lm_strobe)
    );

    typedef struct packed {
        logic [31:0] a;
        logic        as;
        logic        am;
        logic        er;
        logic        em;
    } vec_t;

    // configured group 5, slot 9 -> window base 0xA900_0000
    localparam vec_t VECS [9] = '{
        '{32'hA900_0000, 1'b1, 1'b1, 1'b1, 1'b0},
        '{32'hA900_00FF, 1'b1, 1'b1, 1'b1, 1'b0},
        '{32'hA900_0100, 1'b1, 1'b1, 1'b0, 1'b1},
        '{32'hA9FF_FFFF, 1'b1, 1'b1, 1'b0, 1'b1},
        '{32'hAA00_0000, 1'b1, 1'b1, 1'b0, 1'b0},
        '{32'h8900_0000, 1'b1, 1'b1, 1'b0, 1'b0},
        '{32'hA900_0000, 1'b0, 1'b1, 1'b0, 1'b0},
        '{32'hA900_0100, 1'b1, 1'b0, 1'b0, 1'b0},
        '{32'hBF00_0000, 1'b1, 1'b1, 1'b0, 1'b0}
    };

    function automatic string row_req(input int i);
        case (i)
            0, 1:    return "R3";
            2, 3:    return "R4";
            4, 5:    return "R2";
            6, 7:    return "R9";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] a, input logic s, input logic q);
        @(negedge clk);
        addr = a; as_valid = s; am_ok = q;
        #1;
    endtask

    task automatic do_reset(input logic [7:0] sw);
        @(negedge clk);
        rst = 1'b1; cfg_sw = sw; as_valid = 1'b0; am_ok = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R10: reset state, with a broadcast access present during reset
        repeat (2) @(negedge clk);
        addr = 32'hBF00_0000; as_valid = 1'b1; am_ok = 1'b1;
        @(negedge clk);
        check("R10", "lm_strobe in reset", {31'd0, lm_strobe}, 32'd0);
        as_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;

        // R1: switch change after reset must be ignored
        @(negedge clk);
        cfg_sw = 8'h4C;
        @(negedge clk);

        for (int i = 0; i < 9; i++) begin
            drive(VECS[i].a, VECS[i].as, VECS[i].am);
            check(row_req(i), $sformatf("row %0d reg_sel", i), {31'd0, reg_sel}, {31'd0, VECS[i].er});
            check(row_req(i), $sformatf("row %0d mem_sel", i), {31'd0, mem_sel}, {31'd0, VECS[i].em});
        end

        // R1: new switch window 0x4C00_0000 not decoded
        drive(32'h4C00_0000, 1'b1, 1'b1);
        check("R1", "new window reg_sel", {31'd0, reg_sel}, 32'd0);
        drive(32'hA900_0004, 1'b1, 1'b1);
        check("R1", "old window reg_sel", {31'd0, reg_sel}, 32'd1);
        drive(32'h0, 1'b0, 1'b0);
        @(negedge clk);

        // R6 / R7: held broadcast access
        drive(32'hBF00_0010, 1'b1, 1'b1);
        check("R6", "bcast reg_sel", {31'd0, reg_sel}, 32'd0);
        @(negedge clk); #1;
        check("R6", "lm_strobe after one edge", {31'd0, lm_strobe}, 32'd1);
        @(negedge clk); #1;
        check("R7", "lm_strobe while held", {31'd0, lm_strobe}, 32'd0);
        @(negedge clk); #1;
        check("R7", "lm_strobe still held", {31'd0, lm_strobe}, 32'd0);
        drive(32'hBF00_0010, 1'b0, 1'b1);
        @(negedge clk);
        drive(32'hBF00_0010, 1'b1, 1'b1);
        @(negedge clk); #1;
        check("R7", "lm_strobe on restart", {31'd0, lm_strobe}, 32'd1);
        drive(32'h0, 1'b0, 1'b0);
        @(negedge clk);

        // R9: broadcast without qualifier
        drive(32'hBF00_0000, 1'b1, 1'b0);
        @(negedge clk); #1;
        check("R9", "lm_strobe unqualified", {31'd0, lm_strobe}, 32'd0);

        // R8: broadcast to group 4
        drive(32'h9F00_0000, 1'b1, 1'b1);
        @(negedge clk); #1;
        check("R8", "lm_strobe other group", {31'd0, lm_strobe}, 32'd0);
        @(negedge clk); #1;
        check("R8", "lm_strobe other group later", {31'd0, lm_strobe}, 32'd0);
        drive(32'h0, 1'b0, 1'b0);

        // R5: configured slot 31 in group 5
        do_reset(8'hBF);
        drive(32'hBF00_0000, 1'b1, 1'b1);
        check("R5", "slot31 reg_sel", {31'd0, reg_sel}, 32'd0);
        check("R5", "slot31 mem_sel", {31'd0, mem_sel}, 32'd0);
        drive(32'hBF00_1000, 1'b1, 1'b1);
        check("R5", "slot31 mem_sel high offset", {31'd0, mem_sel}, 32'd0);
        check("R6", "slot31 module lm_strobe", {31'd0, lm_strobe}, 32'd1);
        drive(32'h0, 1'b0, 1'b0);

        // R2: slot 0 of group 0 decodes; its neighbour does not
        do_reset(8'h00);
        drive(32'h0000_0200, 1'b1, 1'b1);
        check("R2", "group0 slot0 mem_sel", {31'd0, mem_sel}, 32'd1);
        drive(32'h0100_0000, 1'b1, 1'b1);
        check("R2", "group0 slot1 reg_sel", {31'd0, reg_sel}, 32'd0);
        drive(32'h0, 1'b0, 1'b0);

        finish_run();
    end
endmodule